// File: doc/BRIEF.md
# Instruction Trace Pending Controller

This block keeps the two status-word bits that drive single-instruction tracing: a trace enable bit and a trace pending bit. At every instruction boundary it decides whether a trace fault must be raised before the next instruction does anything else. At every instruction completion it updates the pair according to the kind of instruction that just finished. The pair is what guarantees exactly one trace per traced instruction, even across mode changes, returns and status writes.

The surrounding sequencer gives it a start strobe at each instruction boundary and a done strobe when an instruction completes. The done strobe comes with a class code and the data needed by the class: the enable bit a status-bit-set instruction writes, or the enable and pending bits of the word a return restores. The sequencer also presents the other exceptions that want to be taken at the boundary. The block answers with a one-cycle trace request, a mask of the other exceptions that may proceed, the enable and pending values to place in a stack frame, and the live enable and pending bits. After a trace request it waits for a handler-entry strobe before it lets any boundary through again. Fetching the vector and running the handlers are left to other logic.

Top module: `trace_pair_ctrl`

## Requirements
- R1: After reset the live enable bit, the live pending bit, the trace request and the pass mask are all 0.
- R2: A start strobe while the pending bit is 1 and no request is awaiting its handler raises the trace request in that same cycle, for exactly one cycle; the pending bit is 0 from the next cycle on, and the enable bit is unchanged.
- R3: A raised trace request takes precedence over every other exception: the pass mask is all zero in that cycle. A start strobe with the pending bit 0 and nothing awaiting a handler passes the other-exception vector unchanged, and outside a start strobe the pass mask is zero.
- R4: Between a trace request and the cycle of the handler-entry strobe, start strobes raise neither a trace request nor any pass bit; from the cycle after the handler-entry strobe, boundaries are served again.
- R5: Class codes are 0 ordinary, 1 change-mode, 2 return, 3 status-bit-set, 4 call; codes 5 to 7 act as ordinary. On completion of an ordinary instruction the enable bit is kept and the pending bit takes the enable bit's value.
- R6: On completion of a change-mode instruction both live bits become 0; the frame values are the old enable bit and the OR of the old pending and old enable bits.
- R7: On completion of a return the enable bit takes the restored enable value and the pending bit becomes the restored pending value ORed with the enable bit held before the return.
- R8: On completion of a status-bit-set instruction the enable bit becomes the OR of the old enable bit and the written bit, and the pending bit takes the old enable bit, so a newly enabled trace is first taken before the second instruction after it.
- R9: On completion of a call the frame enable value is 0 and the frame pending value is the live pending bit; the live enable bit is unchanged and the pending bit takes the enable bit's value.
- R10: For every class other than change-mode and call, the frame values equal the live enable and pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_start | input | 1 | Instruction boundary strobe |
| ins_done | input | 1 | Instruction completion strobe |
| ins_class | input | 3 | Class of the completing instruction |
| wr_en_bit | input | 1 | Enable bit written by a status-bit-set instruction |
| rst_en_bit | input | 1 | Enable bit of the word a return restores |
| rst_pend_bit | input | 1 | Pending bit of the word a return restores |
| other_exc | input | N_EXC | Other exceptions wanting the boundary |
| handler_ack | input | 1 | Trace handler entered |
| trace_req | output | 1 | Trace fault request, one cycle |
| other_pass | output | N_EXC | Other exceptions allowed to proceed |
| frame_en | output | 1 | Enable value for the stack frame |
| frame_pend | output | 1 | Pending value for the stack frame |
| live_en | output | 1 | Live trace enable bit |
| live_pend | output | 1 | Live trace pending bit |

## Verification
The assertions take for granted that a start strobe and a done strobe never arrive in the same cycle, and that the handler-entry strobe only comes while a trace request is outstanding. The random stimulus picks exactly one action per cycle (start, done, or idle) and only raises the handler-entry strobe when the bench's own model says a request is awaiting its handler, while start strobes are still sent during that wait to show they are held off. Directed sequences cover the delayed first trace after a status-bit-set, a change-mode with tracing on, and a return that inherits pending from the old enable bit.

// File: rtl/trace_pair_pkg.sv
package trace_pair_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_PLAIN   = 3'd0,
      CLS_CHMODE  = 3'd1,
      CLS_RETURN  = 3'd2,
      CLS_SETBITS = 3'd3,
      CLS_CALL    = 3'd4
   } ins_cls_e;

   typedef struct packed {
      logic en;
      logic pend;
   } trace_bits_t;
endpackage

// File: rtl/trace_pair_next.sv
module trace_pair_next
   import trace_pair_pkg::*;
(
   input  trace_bits_t           cur,
   input  logic                  done,
   input  logic [CLS_W-1:0]      cls,
   input  logic                  wr_en,
   input  logic                  rs_en,
   input  logic                  rs_pend,
   input  logic                  take,
   output trace_bits_t           nxt
);
   always_comb begin
      nxt = cur;
      if (take) begin
         nxt.pend = 1'b0;
      end else if (done) begin
         case (cls)
            CLS_CHMODE: begin
               nxt.en   = 1'b0;
               nxt.pend = 1'b0;
            end
            CLS_RETURN: begin
               nxt.en   = rs_en;
               nxt.pend = rs_pend | cur.en;
            end
            CLS_SETBITS: begin
               nxt.en   = cur.en | wr_en;
               nxt.pend = cur.en;
            end
            default: begin
               nxt.en   = cur.en;
               nxt.pend = cur.en;
            end
         endcase
      end
   end
endmodule

// File: rtl/trace_pair_frame.sv
module trace_pair_frame
   import trace_pair_pkg::*;
(
   input  trace_bits_t           cur,
   input  logic [CLS_W-1:0]      cls,
   output trace_bits_t           saved
);
   always_comb begin
      saved = cur;
      case (cls)
         CLS_CHMODE: begin
            saved.en   = cur.en;
            saved.pend = cur.pend | cur.en;
         end
         CLS_CALL: begin
            saved.en   = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/trace_pair_boundary.sv
module trace_pair_boundary #(
   parameter int N_EXC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pend,
   input  logic             ack,
   input  logic [N_EXC-1:0] other,
   output logic             req,
   output logic [N_EXC-1:0] pass,
   output logic             busy
);
   logic wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wait_q <= 1'b0;
      else if (req)    wait_q <= 1'b1;
      else if (ack)    wait_q <= 1'b0;
   end

   assign busy = wait_q;
   assign req  = start & pend & ~wait_q;

   logic open_gate;
   assign open_gate = start & ~pend & ~wait_q;

   for (genvar i = 0; i < N_EXC; i++) begin : g_pass
      assign pass[i] = open_gate & other[i];
   end

   assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);
   assert_trace_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (pass == '0));
   assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ack) |=> (!req && pass == '0));
endmodule

// File: rtl/trace_pair_ctrl.sv
module trace_pair_ctrl
   import trace_pair_pkg::*;
#(
   parameter int N_EXC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_start,
   input  logic             ins_done,
   input  logic [2:0]       ins_class,
   input  logic             wr_en_bit,
   input  logic             rst_en_bit,
   input  logic             rst_pend_bit,
   input  logic [N_EXC-1:0] other_exc,
   input  logic             handler_ack,
   output logic             trace_req,
   output logic [N_EXC-1:0] other_pass,
   output logic             frame_en,
   output logic             frame_pend,
   output logic             live_en,
   output logic             live_pend
);
   if (N_EXC < 1 || N_EXC > 64) begin : g_bad_n
      $error("trace_pair_ctrl: N_EXC must be in 1..64");
   end
   if (CLS_W != 3) begin : g_bad_cls
      $error("trace_pair_ctrl: class code width must be 3");
   end

   trace_bits_t cur_q, nxt, saved;
   logic        busy;

   trace_pair_boundary #(.N_EXC(N_EXC)) u_boundary (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ins_start),
      .pend  (cur_q.pend),
      .ack   (handler_ack),
      .other (other_exc),
      .req   (trace_req),
      .pass  (other_pass),
      .busy  (busy)
   );

   trace_pair_next u_next (
      .cur     (cur_q),
      .done    (ins_done),
      .cls     (ins_class),
      .wr_en   (wr_en_bit),
      .rs_en   (rst_en_bit),
      .rs_pend (rst_pend_bit),
      .take    (trace_req),
      .nxt     (nxt)
   );

   trace_pair_frame u_frame (
      .cur   (cur_q),
      .cls   (ins_class),
      .saved (saved)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
   end

   assign live_en    = cur_q.en;
   assign live_pend  = cur_q.pend;
   assign frame_en   = saved.en;
   assign frame_pend = saved.pend;

   assert_take_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trace_req |=> (!live_pend && live_en == $past(live_en)));
   assert_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !ins_start && ins_class == 3'd0) |=> (live_pend == live_en));
   assert_chmode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !ins_start && ins_class == 3'd1) |=> (!live_en && !live_pend));
   assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !ins_start && ins_class == 3'd2 && (live_en || rst_pend_bit)) |=> live_pend);
   assert_setbits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !ins_start && ins_class == 3'd3 && !live_en) |=> !live_pend);
   assert_call_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !ins_start && ins_class == 3'd4) |=> (live_en == $past(live_en)));
   assert_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!live_en && !live_pend));
endmodule

// File: tb/trace_pair_ctrl_bench.sv
module trace_pair_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ins_start = 1'b0, ins_done = 1'b0;
   logic [2:0]   ins_class = '0;
   logic         wr_en_bit = 1'b0, rst_en_bit = 1'b0, rst_pend_bit = 1'b0;
   logic [N-1:0] other_exc = '0;
   logic         handler_ack = 1'b0;
   logic         trace_req, frame_en, frame_pend, live_en, live_pend;
   logic [N-1:0] other_pass;

   int runs = 0, fails = 0;
   bit finished = 0;

   bit m_en = 0, m_pend = 0, m_wait = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_pair_ctrl #(.N_EXC(N)) u_trace_pair_ctrl (
      .clk(clk), .rst_n(rst_n), .ins_start(ins_start), .ins_done(ins_done),
      .ins_class(ins_class), .wr_en_bit(wr_en_bit), .rst_en_bit(rst_en_bit),
      .rst_pend_bit(rst_pend_bit), .other_exc(other_exc), .handler_ack(handler_ack),
      .trace_req(trace_req), .other_pass(other_pass), .frame_en(frame_en),
      .frame_pend(frame_pend), .live_en(live_en), .live_pend(live_pend)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_frame(logic [2:0] c, bit e, bit p);
      if (c == 3'd1) return {e, p | e};
      if (c == 3'd4) return {1'b0, p};
      return {e, p};
   endfunction

   function automatic logic [1:0] exp_next(logic [2:0] c, bit e, bit wr, bit re, bit rp);
      case (c)
         3'd1:    return 2'b00;
         3'd2:    return {re, rp | e};
         3'd3:    return {e | wr, e};
         default: return {e, e};
      endcase
   endfunction

   function automatic string cls_tag(logic [2:0] c);
      case (c)
         3'd1: return "R6";
         3'd2: return "R7";
         3'd3: return "R8";
         3'd4: return "R9";
         default: return "R5";
      endcase
   endfunction

   // one cycle: kind 0 idle, 1 start, 2 done
   task automatic step(int kind, logic [2:0] c, bit wr, bit re, bit rp,
                       logic [N-1:0] oth, bit ack);
      bit e_req;
      logic [N-1:0] e_pass;
      logic [1:0] nx;
      @(negedge clk);
      ins_start = (kind == 1); ins_done = (kind == 2);
      ins_class = c; wr_en_bit = wr; rst_en_bit = re; rst_pend_bit = rp;
      other_exc = oth; handler_ack = ack;
      #1;
      e_req  = (kind == 1) && m_pend && !m_wait;
      e_pass = ((kind == 1) && !m_pend && !m_wait) ? oth : '0;
      check(m_wait ? "R4 req held" : "R2 req", trace_req, e_req);
      check(e_req ? "R3 precedence" : (m_wait ? "R4 pass held" : "R3 pass"), other_pass, e_pass);
      if (kind == 2) begin
         check(c == 3'd1 ? "R6 frame" : (c == 3'd4 ? "R9 frame" : "R10 frame"),
               {frame_en, frame_pend}, exp_frame(c, m_en, m_pend));
      end
      nx = exp_next(c, m_en, wr, re, rp);
      @(posedge clk);
      if (e_req) begin
         m_pend = 0; m_wait = 1;
      end else if (ack) begin
         m_wait = 0;
      end
      if (kind == 2) begin
         m_en = nx[1]; m_pend = nx[0];
      end
      #1;
      check(kind == 2 ? cls_tag(c) : (e_req ? "R2 clear" : "R4 state"),
            {live_en, live_pend}, {m_en, m_pend});
      ins_start = 0; ins_done = 0; handler_ack = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00c0ffee));
      #(CLK_PERIOD * 2 + 2);
      check("R1 en", live_en, 0);
      check("R1 pend", live_pend, 0);
      check("R1 req", trace_req, 0);
      check("R1 pass", other_pass, 0);
      rst_n = 1'b1;

      // status-bit-set enables trace: first trace before second instruction after
      step(2, 3'd3, 1, 0, 0, '0, 0);
      check("R8 no pend yet", live_pend, 0);
      step(1, 0, 0, 0, 0, 4'b0101, 0);           // first instruction: no trace, passes
      step(2, 3'd0, 0, 0, 0, '0, 0);             // completes with enable set
      step(1, 0, 0, 0, 0, 4'b1111, 0);           // trace, others blocked
      step(1, 0, 0, 0, 0, 4'b0011, 0);           // held while waiting
      step(0, 0, 0, 0, 0, '0, 1);                // handler entry
      step(1, 0, 0, 0, 0, 4'b0010, 0);           // served again
      // call with trace on
      step(2, 3'd4, 0, 0, 0, '0, 0);
      // change mode with trace on
      step(2, 3'd1, 0, 0, 0, '0, 0);
      // return from traced old word: pending inherited
      step(2, 3'd3, 1, 0, 0, '0, 0);
      step(2, 3'd2, 0, 0, 0, '0, 0);
      check("R7 pend from old enable", live_pend, 1);
      step(2, 3'd2, 0, 0, 1, '0, 0);
      step(2, 3'd7, 0, 0, 0, '0, 0);

      for (int i = 0; i < 3000; i++) begin
         int k;
         bit ack;
         k = $urandom_range(2, 0);
         ack = m_wait && ($urandom_range(3, 0) == 0);
         step(k, 3'($urandom_range(7, 0)), 1'($urandom), 1'($urandom), 1'($urandom),
              N'($urandom), ack);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end
endmodule